// File: doc/BRIEF.md
# Bus Security Level Checker

This block rules on a single bus transaction. It compares the security level of the master that issues the transaction with the level programmed for the slave it targets. The ruling depends on three things: the kind of access, the class of the master (simple or smart), and a strict-mode enable for that class. An instruction fetch needs the two levels to be equal. A data access either needs the same equality or is allowed when the master is at the slave's level or above, depending on the strict enable. The allow output comes straight from the inputs, with no register on the way.

A denied transaction that is marked valid does two things on the next clock edge. It raises a violation pulse that lasts one cycle, and it may load a syndrome holding the master level, the slave level and the access kind. A small state machine governs the syndrome:

- `SYN_EMPTY` moves to `SYN_HELD` on a denial (capture).
- `SYN_HELD` returns to `SYN_EMPTY` on a clear with no denial in the same cycle (release).
- `SYN_HELD` stays put and reloads when a clear and a denial arrive together (recapture).
- Otherwise `SYN_HELD` stays put (hold). With the first-fault policy, a hold keeps the old syndrome; with the last-fault policy, each new denial overwrites it.

Top module: `sec_access_checker`

## Requirements
- R1: Levels are 2-bit codes ordered 00 (non-secure user) < 01 (non-secure privileged) < 10 (secure user) < 11 (secure privileged). "Lower" and "higher" follow this numeric order.
- R2: An access kind of 00 (instruction fetch) is allowed only when the master level equals the slave level. This holds for both master classes and for any strict setting.
- R3: A simple master (mst_smart=0) with strict_simple=1 is allowed a read (01), write (10) or other access (11) only when the master level equals the slave level.
- R4: A simple master with strict_simple=0 is allowed a non-fetch access when the master level is greater than or equal to the slave level.
- R5: A smart master (mst_smart=1) with strict_smart=1 is allowed a non-fetch access only when the two levels are equal. Each class uses only its own strict enable.
- R6: A smart master with strict_smart=0 is allowed a non-fetch access when its level is greater than or equal to the slave level, and is still allowed fetches only at an equal level.
- R7: Access kind 11 (other) follows exactly the same rule as a data read or write.
- R8: `allow` settles in the same cycle the inputs change, with no clock edge in between.
- R9: `viol_pulse` is high for the one cycle after an edge at which `txn_valid`=1 and `allow`=0, and is low after every other edge. An invalid or allowed transaction raises no pulse.
- R10: A denied valid transaction while `synd_valid`=0 sets `synd_valid` and loads the master level, slave level and access kind after the same edge. The fields are meaningful only while `synd_valid`=1.
- R11: With KEEP_FIRST=1 (the default), later denials do not change a held syndrome unless a clear arrives in the same cycle.
- R12: `clear_synd` with no denial empties the syndrome after the edge. A clear together with a denial loads the new syndrome and leaves `synd_valid`=1.
- R13: After reset, `viol_pulse`=0, `synd_valid`=0 and all syndrome fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_valid | input | 1 | A transaction is presented this cycle |
| mst_level | input | 2 | Security level of the issuing master |
| mst_smart | input | 1 | 1 = smart master, 0 = simple master |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 other |
| slv_level | input | 2 | Security level programmed for the target slave |
| strict_simple | input | 1 | Strict mode for simple masters |
| strict_smart | input | 1 | Strict mode for smart masters |
| clear_synd | input | 1 | Empties the captured syndrome |
| allow | output | 1 | Combinational allow decision |
| viol_pulse | output | 1 | One-cycle pulse after a denied valid transaction |
| synd_valid | output | 1 | A syndrome is held |
| synd_mst_level | output | 2 | Captured master level |
| synd_slv_level | output | 2 | Captured slave level |
| synd_acc_kind | output | 2 | Captured access kind |

## Verification
The assertions check the following on every cycle:
- Fetch equality and strict-mode equality.
- That a relaxed master at or above the slave's level is allowed.
- That each pulse has a denied valid transaction as its cause.
- The capture, hold and release of the syndrome.

The bench shows what the assertions cannot. It sweeps every combination of level, class, access kind and strict setting against an independent model. This brings out the exact deny set and shows that each strict enable applies only to its own class. The bench also runs ordered scenarios that reach the first-fault hold, a clear together with a denial, and a denied transaction without `txn_valid`.

// File: rtl/sec_chk_pkg.sv
package sec_chk_pkg;
    localparam int LVL_W = 2;
    localparam int ACC_W = 2;

    typedef enum logic [ACC_W-1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_OTHER = 2'b11
    } acc_kind_e;

    typedef enum logic {
        SYN_EMPTY = 1'b0,
        SYN_HELD  = 1'b1
    } syn_state_e;

    typedef struct packed {
        logic [LVL_W-1:0] mst;
        logic [LVL_W-1:0] slv;
        logic [ACC_W-1:0] acc;
    } syndrome_t;
endpackage

// File: rtl/sec_rule_eval.sv
module sec_rule_eval
    import sec_chk_pkg::*;
(
    input  logic [LVL_W-1:0] mst_level,
    input  logic             mst_smart,
    input  logic [ACC_W-1:0] acc_kind,
    input  logic [LVL_W-1:0] slv_level,
    input  logic             strict_simple,
    input  logic             strict_smart,
    output logic             allow
);
    logic is_fetch;
    logic strict_sel;
    logic lvl_equal;
    logic lvl_dominates;

    always_comb begin
        is_fetch      = (acc_kind == ACC_FETCH);
        strict_sel    = mst_smart ? strict_smart : strict_simple;
        lvl_equal     = (mst_level == slv_level);
        lvl_dominates = (mst_level >= slv_level);
        if (is_fetch) begin
            // instruction fetch: exact level match for every class
            allow = lvl_equal;
        end else if (strict_sel) begin
            allow = lvl_equal;
        end else begin
            allow = lvl_dominates;
        end
    end
endmodule

// File: rtl/sec_syndrome_fsm.sv
module sec_syndrome_fsm
    import sec_chk_pkg::*;
#(
    parameter bit KEEP_FIRST = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      deny_evt,
    input  logic      clear_synd,
    input  syndrome_t syn_in,
    output logic      viol_pulse,
    output logic      synd_valid,
    output syndrome_t synd_out
);
    syn_state_e state_q;
    syn_state_e state_nx;
    logic       capture;
    logic       may_overwrite;
    logic       pulse_q;
    syndrome_t  synd_q;

    generate
        if (KEEP_FIRST) begin : g_first_fault
            assign may_overwrite = clear_synd;
        end else begin : g_last_fault
            assign may_overwrite = 1'b1;
        end
    endgenerate

    always_comb begin
        state_nx = state_q;
        capture  = 1'b0;
        unique case (state_q)
            SYN_EMPTY: begin
                if (deny_evt) begin
                    capture  = 1'b1;
                    state_nx = SYN_HELD;
                end
            end
            SYN_HELD: begin
                if (deny_evt && may_overwrite) begin
                    capture = 1'b1;
                end
                if (clear_synd && !deny_evt) begin
                    state_nx = SYN_EMPTY;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SYN_EMPTY;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            synd_q  <= '0;
        end else begin
            pulse_q <= deny_evt;
            if (capture) begin
                synd_q <= syn_in;
            end
        end
    end

    assign viol_pulse = pulse_q;
    assign synd_valid = (state_q == SYN_HELD);
    assign synd_out   = synd_q;
endmodule

// File: rtl/sec_access_checker.sv
module sec_access_checker
    import sec_chk_pkg::*;
#(
    parameter bit KEEP_FIRST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_valid,
    input  logic [LVL_W-1:0] mst_level,
    input  logic             mst_smart,
    input  logic [ACC_W-1:0] acc_kind,
    input  logic [LVL_W-1:0] slv_level,
    input  logic             strict_simple,
    input  logic             strict_smart,
    input  logic             clear_synd,
    output logic             allow,
    output logic             viol_pulse,
    output logic             synd_valid,
    output logic [LVL_W-1:0] synd_mst_level,
    output logic [LVL_W-1:0] synd_slv_level,
    output logic [ACC_W-1:0] synd_acc_kind
);
    logic      allow_w;
    logic      deny_evt;
    syndrome_t syn_now;
    syndrome_t syn_held;

    sec_rule_eval u_rule (
        .mst_level     (mst_level),
        .mst_smart     (mst_smart),
        .acc_kind      (acc_kind),
        .slv_level     (slv_level),
        .strict_simple (strict_simple),
        .strict_smart  (strict_smart),
        .allow         (allow_w)
    );

    assign deny_evt    = txn_valid & ~allow_w;
    assign syn_now.mst = mst_level;
    assign syn_now.slv = slv_level;
    assign syn_now.acc = acc_kind;

    sec_syndrome_fsm #(
        .KEEP_FIRST (KEEP_FIRST)
    ) u_synd (
        .clk        (clk),
        .rst_n      (rst_n),
        .deny_evt   (deny_evt),
        .clear_synd (clear_synd),
        .syn_in     (syn_now),
        .viol_pulse (viol_pulse),
        .synd_valid (synd_valid),
        .synd_out   (syn_held)
    );

    assign allow          = allow_w;
    assign synd_mst_level = syn_held.mst;
    assign synd_slv_level = syn_held.slv;
    assign synd_acc_kind  = syn_held.acc;
endmodule

// File: rtl/sec_access_checker_sva.sv
module sec_access_checker_sva
    import sec_chk_pkg::*;
#(
    parameter bit KEEP_FIRST = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txn_valid,
    input logic [LVL_W-1:0] mst_level,
    input logic             mst_smart,
    input logic [ACC_W-1:0] acc_kind,
    input logic [LVL_W-1:0] slv_level,
    input logic             strict_simple,
    input logic             strict_smart,
    input logic             clear_synd,
    input logic             allow,
    input logic             viol_pulse,
    input logic             synd_valid,
    input logic [LVL_W-1:0] synd_mst_level,
    input logic [LVL_W-1:0] synd_slv_level,
    input logic [ACC_W-1:0] synd_acc_kind
);
    logic class_strict;
    assign class_strict = (mst_smart && strict_smart) || (!mst_smart && strict_simple);

    a_r2_fetch_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == ACC_FETCH && allow) |-> (mst_level == slv_level));

    // R3 and R5: strict class allows only an exact level
    a_r3_strict_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind != ACC_FETCH && class_strict && allow) |-> (mst_level == slv_level));

    // R4 and R6: relaxed class allows its own level and above
    a_r4_relaxed_dominates: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind != ACC_FETCH && !class_strict && mst_level >= slv_level) |-> allow);

    a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> $past(txn_valid && !allow));

    a_r9_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !allow) |=> viol_pulse);

    a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !allow && (!synd_valid || clear_synd)) |=>
        (synd_valid && synd_mst_level == $past(mst_level) &&
         synd_slv_level == $past(slv_level) && synd_acc_kind == $past(acc_kind)));

    a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_synd && !(txn_valid && !allow)) |=> !synd_valid);

    generate
        if (KEEP_FIRST) begin : g_hold_chk
            a_r11_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
                (synd_valid && !clear_synd) |=>
                (synd_valid && $stable(synd_mst_level) &&
                 $stable(synd_slv_level) && $stable(synd_acc_kind)));
        end
    endgenerate
endmodule

bind sec_access_checker sec_access_checker_sva #(.KEEP_FIRST(KEEP_FIRST)) u_sva (.*);

// File: tb/sec_access_checker_tb_top.sv
module sec_access_checker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_valid = 1'b0;
    logic [1:0] mst_level = '0;
    logic       mst_smart = 1'b0;
    logic [1:0] acc_kind = '0;
    logic [1:0] slv_level = '0;
    logic       strict_simple = 1'b0;
    logic       strict_smart = 1'b0;
    logic       clear_synd = 1'b0;
    logic       allow;
    logic       viol_pulse;
    logic       synd_valid;
    logic [1:0] synd_mst_level;
    logic [1:0] synd_slv_level;
    logic [1:0] synd_acc_kind;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit       pulse;
        bit       sv;
        bit [1:0] ml;
        bit [1:0] sl;
        bit [1:0] ak;
        string    tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    // bench model of the held syndrome
    bit       m_sv = 1'b0;
    bit [1:0] m_ml = '0;
    bit [1:0] m_sl = '0;
    bit [1:0] m_ak = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_access_checker dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .txn_valid      (txn_valid),
        .mst_level      (mst_level),
        .mst_smart      (mst_smart),
        .acc_kind       (acc_kind),
        .slv_level      (slv_level),
        .strict_simple  (strict_simple),
        .strict_smart   (strict_smart),
        .clear_synd     (clear_synd),
        .allow          (allow),
        .viol_pulse     (viol_pulse),
        .synd_valid     (synd_valid),
        .synd_mst_level (synd_mst_level),
        .synd_slv_level (synd_slv_level),
        .synd_acc_kind  (synd_acc_kind)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_allow(bit [1:0] m, bit smart, bit [1:0] a,
                                     bit [1:0] s, bit ss, bit sm);
        bit strict;
        if (a == 2'b00) return (m == s);
        strict = smart ? sm : ss;
        return strict ? (m == s) : (m >= s);
    endfunction

    function automatic string rule_tag(bit smart, bit [1:0] a, bit ss, bit sm);
        if (a == 2'b00) return "R2";
        if (a == 2'b11) return "R7";
        if (!smart) return ss ? "R3" : "R4";
        return sm ? "R5" : "R6";
    endfunction

    task automatic drive(input bit [1:0] m, input bit smart, input bit [1:0] a,
                         input bit [1:0] s, input bit ss, input bit sm,
                         input bit v, input bit clr,
                         input string tag_a, input string tag_s);
        bit ea;
        bit deny;
        exp_item_t it;
        @(negedge clk);
        mst_level = m; mst_smart = smart; acc_kind = a; slv_level = s;
        strict_simple = ss; strict_smart = sm; txn_valid = v; clear_synd = clr;
        #1;
        ea = exp_allow(m, smart, a, s, ss, sm);
        check(allow == ea, (tag_a == "") ? rule_tag(smart, a, ss, sm) : tag_a,
              "allow", int'(allow), int'(ea));
        deny = v && !ea;
        if (clr) m_sv = 1'b0;
        if (deny && !m_sv) begin
            m_sv = 1'b1; m_ml = m; m_sl = s; m_ak = a;
        end
        it.pulse = deny; it.sv = m_sv; it.ml = m_ml; it.sl = m_sl; it.ak = m_ak;
        it.tag = tag_s;
        sb_q.push_back(it);
    endtask

    // monitor: compares after each edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            check(viol_pulse == it.pulse, "R9", "viol_pulse", int'(viol_pulse), int'(it.pulse));
            check(synd_valid == it.sv, it.tag, "synd_valid", int'(synd_valid), int'(it.sv));
            if (it.sv) begin
                check(synd_mst_level == it.ml, it.tag, "synd_mst_level",
                      int'(synd_mst_level), int'(it.ml));
                check(synd_slv_level == it.sl, it.tag, "synd_slv_level",
                      int'(synd_slv_level), int'(it.sl));
                check(synd_acc_kind == it.ak, it.tag, "synd_acc_kind",
                      int'(synd_acc_kind), int'(it.ak));
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R13 reset state
        check(viol_pulse == 1'b0, "R13", "viol_pulse", int'(viol_pulse), 0);
        check(synd_valid == 1'b0, "R13", "synd_valid", int'(synd_valid), 0);
        check({synd_mst_level, synd_slv_level, synd_acc_kind} == 6'd0, "R13", "fields",
              int'({synd_mst_level, synd_slv_level, synd_acc_kind}), 0);

        // R1 order: secure user above non-secure privileged
        drive(2'b10, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R1", "R1");
        drive(2'b01, 1'b0, 2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, "R1", "R1");
        drive(2'b11, 1'b1, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R1", "R1");

        // R8: allow follows inputs within the cycle
        @(negedge clk);
        mst_level = 2'b00; slv_level = 2'b11; acc_kind = 2'b01; mst_smart = 1'b0;
        strict_simple = 1'b0; txn_valid = 1'b0; clear_synd = 1'b0;
        #1;
        check(allow == 1'b0, "R8", "allow before change", int'(allow), 0);
        slv_level = 2'b00;
        #1;
        check(allow == 1'b1, "R8", "allow same cycle", int'(allow), 1);

        // R9: invalid denied transaction makes no pulse
        drive(2'b00, 1'b0, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "R9", "R9");

        // exhaustive sweep with a clear each cycle: every denial captures
        for (int ss = 0; ss < 2; ss++)
            for (int sm = 0; sm < 2; sm++)
                for (int smart = 0; smart < 2; smart++)
                    for (int a = 0; a < 4; a++)
                        for (int m = 0; m < 4; m++)
                            for (int s = 0; s < 4; s++)
                                drive(2'(m), 1'(smart), 2'(a), 2'(s), 1'(ss), 1'(sm),
                                      1'b1, 1'b1, "", "R10");

        // R12 release
        drive(2'b00, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R4", "R12");
        // R10 capture into empty
        drive(2'b00, 1'b0, 2'b10, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, "R4", "R10");
        // R11 later denials keep the first syndrome
        drive(2'b01, 1'b1, 2'b00, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, "R2", "R11");
        drive(2'b10, 1'b0, 2'b11, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, "R7", "R11");
        drive(2'b11, 1'b1, 2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, "R6", "R11");
        // R5 strict smart denies lower slave; R3 strict simple exact only
        drive(2'b11, 1'b1, 2'b01, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, "R5", "R11");
        drive(2'b11, 1'b0, 2'b10, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, "R3", "R11");
        // R12 clear plus denial recaptures
        drive(2'b10, 1'b0, 2'b01, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, "R4", "R12");
        drive(2'b00, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R4", "R12");
        drive(2'b00, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R4", "R12");

        @(negedge clk);
        txn_valid = 1'b0; clear_synd = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule